// File: doc/BRIEF.md
# Burst Request Acceptance Front-End

This block is the local-side request port of a memory controller. A client presents read or write bursts. Each burst carries a start address, a beat count and a strobe that marks the first transfer. The block decides in each cycle whether it takes the request, and it drives a single ready output for back-pressure. Every burst it takes becomes one entry in a small in-order command queue, which the scheduler behind it drains with a pop strobe.

Write bursts carry their data beats on the same request lines. The block counts the accepted beats against the burst's length and passes each one on as a registered write beat with a last-beat marker. While a write burst is still open, no new burst can begin. The block also catches illegal request patterns and reports them on a one-cycle error pulse. A request that is flagged this way is never taken.

Top module: `burst_req_frontend`

## Requirements
- R1: A request (`lcl_rd` or `lcl_wr` high) is accepted exactly when it is legal and `lcl_ready` is high in that same cycle; a request that is not accepted leaves no trace in the queue or on the write-beat output.
- R2: The queue holds `DEPTH` (default 8) burst commands and returns them in the order they were accepted; `lcl_ready` is low whenever `DEPTH` commands are pending.
- R3: `lcl_ready` is low in every cycle where `rdq_full` or `wrq_full` is high.
- R4: With no write burst open, a first-transfer strobe (`lcl_first`=1) that comes with a request while `lcl_ready` is low is recorded. The next accepted request is then treated as a first transfer even when its own strobe is 0.
- R5: A burst's address and length come from the cycle of its strobe. When the strobe was recorded under back-pressure, the address and length presented later are ignored, and the queued command carries the recorded values.
- R6: The length must be from 1 to `MAX_BURST` (default 1024). A first transfer with length 0 or above `MAX_BURST` is flagged as an error and is not accepted.
- R7: `lcl_rd` and `lcl_wr` high together is flagged as an error, and neither request is accepted.
- R8: `lcl_ready` is low while `rst_n` is low and in the first clock cycle after it is released.
- R9: Accepting the first beat of a write burst of length N opens the burst. The next N-1 accepted write beats are data only and push no command. A strobe during an open burst is ignored. A read during an open burst is flagged as an error and is not accepted.
- R10: Each accepted write beat appears on `wbeat_valid`/`wbeat_data` one clock cycle after acceptance. `wbeat_last` is 1 on the Nth beat of a burst of length N.
- R11: With no write burst open and no recorded strobe, a request whose `lcl_first` is 0 is flagged as an error and is not accepted.
- R12: `lcl_err` is a one-cycle pulse in the cycle after an illegal request. `cmd_valid` is high while the queue is not empty. `cmd_pop` removes the head entry, and a pop on an empty queue has no effect. `cmd_write` is 1 for a write burst and 0 for a read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lcl_rd | input | 1 | Read burst request |
| lcl_wr | input | 1 | Write request (first beat or data beat) |
| lcl_first | input | 1 | Marks the first transfer of a burst |
| lcl_addr | input | ADDR_W | Burst start address |
| lcl_len | input | LEN_W | Burst length in beats, binary |
| lcl_wdata | input | DATA_W | Write beat data |
| rdq_full | input | 1 | Read-data FIFO full flag |
| wrq_full | input | 1 | Write-data FIFO full flag |
| lcl_ready | output | 1 | Request can be accepted this cycle |
| lcl_err | output | 1 | Illegal request seen in the previous cycle |
| cmd_valid | output | 1 | Queue head is valid |
| cmd_write | output | 1 | Head command is a write burst |
| cmd_addr | output | ADDR_W | Head command start address |
| cmd_len | output | LEN_W | Head command length |
| cmd_pop | input | 1 | Removes the head command |
| wbeat_valid | output | 1 | Registered accepted write beat |
| wbeat_data | output | DATA_W | Data of that beat |
| wbeat_last | output | 1 | That beat ends its burst |

## Verification
The hardest state to reach from the ports is a strobe recorded under back-pressure, followed by a later accepted request whose own address and length differ. This needs a full flag or a full queue in exactly the strobe cycle, and then the stall must clear while the request is still held. A directed sequence forces it with `rdq_full` and checks that the queued command carries the recorded values. The long random run raises both full flags and stops popping often enough that the same interleaving recurs, including the case where it happens inside an open write burst. A directed write burst of the maximum length also opens the full counter range, with a stray strobe and a read injected mid-burst.

// File: rtl/bfe_pkg.sv
`timescale 1ns/1ps
package bfe_pkg;

    typedef enum logic [0:0] {
        PH_IDLE   = 1'b0,
        PH_WBURST = 1'b1
    } phase_e;

endpackage

// File: rtl/bfe_cmd_queue.sv
`timescale 1ns/1ps
module bfe_cmd_queue #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 11,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              push_write,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [LEN_W-1:0]  push_len,
    input  logic              pop,
    output logic              out_valid,
    output logic              out_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic              full,
    output logic [CNT_W-1:0]  level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t q_q, q_d;

    logic              slot_write [DEPTH];
    logic [ADDR_W-1:0] slot_addr  [DEPTH];
    logic [LEN_W-1:0]  slot_len   [DEPTH];

    logic do_push, do_pop;

    assign do_push = push && (q_q.cnt != FULL_LVL);
    assign do_pop  = pop && (q_q.cnt != '0);

    always_comb begin
        q_d = q_q;
        if (do_push) begin
            q_d.wp = (q_q.wp == LAST_PTR) ? '0 : q_q.wp + 1'b1;
        end
        if (do_pop) begin
            q_d.rp = (q_q.rp == LAST_PTR) ? '0 : q_q.rp + 1'b1;
        end
        q_d.cnt = q_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slot_write[q_q.wp] <= push_write;
            slot_addr[q_q.wp]  <= push_addr;
            slot_len[q_q.wp]   <= push_len;
        end
    end

    assign out_valid = (q_q.cnt != '0);
    assign out_write = slot_write[q_q.rp];
    assign out_addr  = slot_addr[q_q.rp];
    assign out_len   = slot_len[q_q.rp];
    assign full      = (q_q.cnt == FULL_LVL);
    assign level     = q_q.cnt;

endmodule

// File: rtl/bfe_burst_track.sv
`timescale 1ns/1ps
module bfe_burst_track
    import bfe_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = 11,
    parameter int DATA_W    = 32,
    parameter int MAX_BURST = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic              first,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    output logic              push,
    output logic              push_write,
    output logic [ADDR_W-1:0] push_addr,
    output logic [LEN_W-1:0]  push_len,
    output logic              err,
    output logic              wbeat_valid,
    output logic [DATA_W-1:0] wbeat_data,
    output logic              wbeat_last,
    output logic              burst_open
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BURST);
    localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);

    typedef struct packed {
        phase_e            ph;
        logic [LEN_W-1:0]  left;
        logic              held;
        logic [ADDR_W-1:0] h_addr;
        logic [LEN_W-1:0]  h_len;
        logic              err;
        logic              wv;
        logic [DATA_W-1:0] wd;
        logic              wl;
    } trk_t;

    trk_t s_q, s_d;

    logic              req_any, both, is_first, len_ok, bad, accept;
    logic [ADDR_W-1:0] eff_addr;
    logic [LEN_W-1:0]  eff_len;

    always_comb begin
        req_any  = rd | wr;
        both     = rd & wr;
        eff_addr = s_q.held ? s_q.h_addr : addr;
        eff_len  = s_q.held ? s_q.h_len  : len;
        is_first = first | s_q.held;
        len_ok   = (eff_len != '0) && (eff_len <= MAX_LEN);

        if (s_q.ph == PH_IDLE) begin
            bad = both | (req_any & ~is_first) | (req_any & is_first & ~len_ok);
        end else begin
            bad = rd;
        end
        accept = req_any & ready & ~bad;
        push   = accept & (s_q.ph == PH_IDLE);

        s_d     = s_q;
        s_d.err = bad;
        s_d.wv  = accept & wr;
        s_d.wd  = wdata;
        s_d.wl  = 1'b0;

        if (s_q.ph == PH_IDLE) begin
            if (push) begin
                s_d.held = 1'b0;
                if (wr) begin
                    s_d.wl = (eff_len == ONE_LEN);
                    if (eff_len != ONE_LEN) begin
                        s_d.ph   = PH_WBURST;
                        s_d.left = eff_len - ONE_LEN;
                    end
                end
            end else if (first && req_any && !bad && !ready && !s_q.held) begin
                s_d.held   = 1'b1;
                s_d.h_addr = addr;
                s_d.h_len  = len;
            end
        end else if (accept) begin
            s_d.wl   = (s_q.left == ONE_LEN);
            s_d.left = s_q.left - ONE_LEN;
            if (s_q.left == ONE_LEN) begin
                s_d.ph = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign push_write  = wr;
    assign push_addr   = eff_addr;
    assign push_len    = eff_len;
    assign err         = s_q.err;
    assign wbeat_valid = s_q.wv;
    assign wbeat_data  = s_q.wd;
    assign wbeat_last  = s_q.wl;
    assign burst_open  = (s_q.ph == PH_WBURST);

endmodule

// File: rtl/burst_req_frontend.sv
`timescale 1ns/1ps
module burst_req_frontend #(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 32,
    parameter int MAX_BURST = 1024,
    parameter int DEPTH     = 8,
    parameter int LEN_W     = $clog2(MAX_BURST) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcl_rd,
    input  logic              lcl_wr,
    input  logic              lcl_first,
    input  logic [ADDR_W-1:0] lcl_addr,
    input  logic [LEN_W-1:0]  lcl_len,
    input  logic [DATA_W-1:0] lcl_wdata,
    input  logic              rdq_full,
    input  logic              wrq_full,
    output logic              lcl_ready,
    output logic              lcl_err,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_pop,
    output logic              wbeat_valid,
    output logic [DATA_W-1:0] wbeat_data,
    output logic              wbeat_last
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic up;
    } top_t;

    top_t t_q, t_d;

    logic              q_push, q_full, wb_open;
    logic              p_write;
    logic [ADDR_W-1:0] p_addr;
    logic [LEN_W-1:0]  p_len;
    logic [CNT_W-1:0]  q_level;

    always_comb begin
        t_d    = t_q;
        t_d.up = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign lcl_ready = t_q.up && !q_full && !rdq_full && !wrq_full;

    bfe_burst_track #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .DATA_W    (DATA_W),
        .MAX_BURST (MAX_BURST)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd          (lcl_rd),
        .wr          (lcl_wr),
        .first       (lcl_first),
        .addr        (lcl_addr),
        .len         (lcl_len),
        .wdata       (lcl_wdata),
        .ready       (lcl_ready),
        .push        (q_push),
        .push_write  (p_write),
        .push_addr   (p_addr),
        .push_len    (p_len),
        .err         (lcl_err),
        .wbeat_valid (wbeat_valid),
        .wbeat_data  (wbeat_data),
        .wbeat_last  (wbeat_last),
        .burst_open  (wb_open)
    );

    bfe_cmd_queue #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .push_write (p_write),
        .push_addr  (p_addr),
        .push_len   (p_len),
        .pop        (cmd_pop),
        .out_valid  (cmd_valid),
        .out_write  (cmd_write),
        .out_addr   (cmd_addr),
        .out_len    (cmd_len),
        .full       (q_full),
        .level      (q_level)
    );

endmodule

// File: rtl/bfe_checker.sv
`timescale 1ns/1ps
module bfe_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lcl_rd,
    input logic             lcl_wr,
    input logic             rdq_full,
    input logic             wrq_full,
    input logic             lcl_ready,
    input logic             lcl_err,
    input logic             wbeat_valid,
    input logic [CNT_W-1:0] q_level,
    input logic             q_push,
    input logic             wb_open
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    AST_PUSH_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> lcl_ready); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_level == FULL_LVL) |-> (!lcl_ready && !q_push)); // R2

    AST_FLAG_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rdq_full || wrq_full) |-> !lcl_ready); // R3

    AST_DUAL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_rd && lcl_wr) |=> (lcl_err && !wbeat_valid)); // R7

    AST_WAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lcl_ready); // R8

    AST_READ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_open && lcl_rd) |-> !q_push); // R9

    AST_READ_IN_BURST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_open && lcl_rd) |=> lcl_err); // R9

endmodule

bind burst_req_frontend bfe_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lcl_rd      (lcl_rd),
    .lcl_wr      (lcl_wr),
    .rdq_full    (rdq_full),
    .wrq_full    (wrq_full),
    .lcl_ready   (lcl_ready),
    .lcl_err     (lcl_err),
    .wbeat_valid (wbeat_valid),
    .q_level     (q_level),
    .q_push      (q_push),
    .wb_open     (wb_open)
);

// File: tb/tb_burst_req_frontend.sv
`timescale 1ns/1ps
module tb_burst_req_frontend;
    localparam int ADDR_W    = 24;
    localparam int DATA_W    = 32;
    localparam int MAX_BURST = 1024;
    localparam int DEPTH     = 8;
    localparam int LEN_W     = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lcl_rd = 1'b0, lcl_wr = 1'b0, lcl_first = 1'b0;
    logic [ADDR_W-1:0] lcl_addr = '0;
    logic [LEN_W-1:0]  lcl_len = '0;
    logic [DATA_W-1:0] lcl_wdata = '0;
    logic              rdq_full = 1'b0, wrq_full = 1'b0, cmd_pop = 1'b0;
    logic              lcl_ready, lcl_err, cmd_valid, cmd_write;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LEN_W-1:0]  cmd_len;
    logic              wbeat_valid, wbeat_last;
    logic [DATA_W-1:0] wbeat_data;

    burst_req_frontend #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST), .DEPTH(DEPTH), .LEN_W(LEN_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .lcl_rd(lcl_rd), .lcl_wr(lcl_wr), .lcl_first(lcl_first),
        .lcl_addr(lcl_addr), .lcl_len(lcl_len), .lcl_wdata(lcl_wdata),
        .rdq_full(rdq_full), .wrq_full(wrq_full), .lcl_ready(lcl_ready), .lcl_err(lcl_err),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_pop(cmd_pop), .wbeat_valid(wbeat_valid), .wbeat_data(wbeat_data),
        .wbeat_last(wbeat_last)
    );

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    bit          m_up = 0;
    int          m_cnt = 0, m_hd = 0, m_tl = 0;
    bit          qw [DEPTH];
    int          qa [DEPTH];
    int          ql [DEPTH];
    bit          m_hold = 0;
    int          m_ha = 0, m_hl = 0;
    bit          m_wb = 0;
    int          m_left = 0;
    bit          e_err, e_wv, e_wl;
    logic [31:0] e_wd;
    string       e_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit len_legal(input int l);
        return (l >= 1) && (l <= MAX_BURST);
    endfunction

    task automatic step(input bit rd, input bit wr, input bit first, input int addr,
                        input int len, input logic [31:0] data, input bit rf,
                        input bit wf, input bit pop);
        bit r, bad, acc, isf;
        int ea, el;
        string rtag;
        lcl_rd = rd; lcl_wr = wr; lcl_first = first;
        lcl_addr = addr[ADDR_W-1:0]; lcl_len = len[LEN_W-1:0]; lcl_wdata = data;
        rdq_full = rf; wrq_full = wf; cmd_pop = pop;
        #3;
        r = m_up && (m_cnt < DEPTH) && !rf && !wf;
        rtag = !m_up ? "R8" : (m_cnt == DEPTH) ? "R2" : (rf || wf) ? "R3" : "R1";
        chk(lcl_ready == r, rtag, "ready", lcl_ready, r);
        chk(cmd_valid == (m_cnt > 0), "R12", "cmd_valid", cmd_valid, m_cnt > 0);
        if (m_cnt > 0) begin
            chk(cmd_write == qw[m_hd], "R12", "cmd_write", cmd_write, qw[m_hd]);
            chk(cmd_addr == qa[m_hd][ADDR_W-1:0], "R5", "cmd_addr", cmd_addr, qa[m_hd]);
            chk(cmd_len == ql[m_hd][LEN_W-1:0], "R5", "cmd_len", cmd_len, ql[m_hd]);
        end
        ea  = m_hold ? m_ha : addr;
        el  = m_hold ? m_hl : len;
        isf = first || m_hold;
        e_tag = "R1";
        if (!m_wb) begin
            bad = 0;
            if (rd && wr) begin bad = 1; e_tag = "R7"; end
            else if ((rd || wr) && !isf) begin bad = 1; e_tag = "R11"; end
            else if ((rd || wr) && !len_legal(el)) begin bad = 1; e_tag = "R6"; end
        end else begin
            bad = rd;
            if (rd) e_tag = "R9";
        end
        acc   = (rd || wr) && r && !bad;
        e_err = bad; e_wv = acc && wr; e_wd = data; e_wl = 0;
        if (pop && m_cnt > 0) begin
            m_hd = (m_hd + 1) % DEPTH;
            m_cnt--;
        end
        if (!m_wb) begin
            if (acc) begin
                qw[m_tl] = wr; qa[m_tl] = ea; ql[m_tl] = el;
                m_tl = (m_tl + 1) % DEPTH;
                m_cnt++;
                m_hold = 0;
                if (wr) begin
                    e_wl = (el == 1);
                    if (el != 1) begin m_wb = 1; m_left = el - 1; end
                end
            end else if (first && (rd || wr) && !bad && !r && !m_hold) begin
                m_hold = 1; m_ha = addr; m_hl = len;
            end
        end else if (acc) begin
            e_wl = (m_left == 1);
            m_left--;
            if (m_left == 0) m_wb = 0;
        end
        @(posedge clk);
        m_up = 1;
        #1;
        chk(lcl_err == e_err, e_tag, "err", lcl_err, e_err);
        chk(wbeat_valid == e_wv, "R10", "wbeat_valid", wbeat_valid, e_wv);
        if (e_wv) begin
            chk(wbeat_data == e_wd, "R10", "wbeat_data", wbeat_data, e_wd);
            chk(wbeat_last == e_wl, "R9", "wbeat_last", wbeat_last, e_wl);
        end
        @(negedge clk);
    endtask

    task automatic idle(input bit pop);
        step(0, 0, 0, 0, 1, 32'h0, 0, 0, pop);
    endtask

    initial begin
        #1_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: quiet outputs while in reset
        chk(lcl_ready == 0, "R8", "ready in reset", lcl_ready, 0);
        chk(cmd_valid == 0, "R12", "cmd_valid in reset", cmd_valid, 0);
        chk(lcl_err == 0, "R12", "err in reset", lcl_err, 0);
        chk(wbeat_valid == 0, "R10", "wbeat in reset", wbeat_valid, 0);
        rst_n = 1'b1;

        // R8: first cycle after release, request refused
        step(1, 0, 1, 24'h000111, 2, 0, 0, 0, 0);
        idle(1);

        // R2: fill queue, refuse one more, drain in order
        for (int i = 0; i < DEPTH; i++) step(1, 0, 1, 'h100 + i, 1 + i, 0, 0, 0, 0);
        step(1, 0, 0, 'h999, 3, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH + 1; i++) idle(1);

        // R4 / R5: strobe recorded under back-pressure, later values ignored
        step(1, 0, 1, 'hABCDE, 3, 0, 1, 0, 0);
        step(1, 0, 0, 'h55555, 5, 0, 0, 0, 0);
        #3;
        chk(cmd_addr == 24'hABCDE, "R4", "held addr", cmd_addr, 'hABCDE);
        chk(cmd_len == 11'd3, "R5", "held len", cmd_len, 3);
        @(negedge clk);
        idle(1);

        // R6: illegal lengths
        step(0, 1, 1, 'h10, 0, 32'h1, 0, 0, 0);
        step(0, 1, 1, 'h10, MAX_BURST + 1, 32'h2, 0, 0, 0);
        // R7: both requests
        step(1, 1, 1, 'h20, 2, 32'h3, 0, 0, 0);
        // R10: single-beat write
        step(0, 1, 1, 'h30, 1, 32'hCAFE0001, 0, 0, 1);

        // R9: longest write burst with stray strobe and read inside
        step(0, 1, 1, 'h40, MAX_BURST, 32'hD0000000, 0, 0, 1);
        for (int i = 1; i < MAX_BURST; i++) begin
            if (i == 5) step(0, 1, 1, 'h77, 2, 32'hD0000000 + i, 0, 0, 1);
            else if (i == 9) step(1, 0, 1, 'h78, 2, 32'h0, 0, 0, 1);
            else if (i == 20) step(0, 1, 0, 'h0, 1, 32'hD0000000 + i, 0, 1, 1);
            else step(0, 1, 0, 'h0, 1, 32'hD0000000 + i, 0, 0, 1);
        end
        for (int i = 0; i < 12; i++) step(0, 1, 0, 'h0, 1, 32'hEE, 0, 0, 1);
        for (int i = 0; i < 3; i++) idle(1);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit rd, wr, fs, rf, wf, pp;
            int ln;
            rd = ($urandom % 100) < 25;
            wr = ($urandom % 100) < 45;
            if (rd && wr && ($urandom % 8) != 0) wr = 0;
            fs = ($urandom % 100) < 50;
            if (($urandom % 16) == 0) ln = (($urandom % 2) == 0) ? 0 : MAX_BURST + 1;
            else ln = 1 + ($urandom % 4);
            rf = ($urandom % 100) < 8;
            wf = ($urandom % 100) < 8;
            pp = ($urandom % 100) < 45;
            step(rd, wr, fs, $urandom % (1 << ADDR_W), ln, $urandom, rf, wf, pp);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule